// File: doc/BRIEF.md
# Multiply Result Rounding and Exception Unit

This unit sits at the back end of a single-precision multiplier. The core supplies a sign, a signed exponent that is not yet rounded and still carries the bias, and a 24-bit significand with its hidden bit at the top, plus the guard bit and a sticky bit that collects every lower product bit. The unit rounds under one of four modes and renormalizes when rounding carries out of the fraction. It then sorts the value into normal range, overflow or underflow, and emits the packed 32-bit result together with the status flags to raise and a trap-cause vector.

Overflow and underflow each have two behaviours, selected by a trap enable. With the trap off, the result saturates to infinity or the largest finite value, or it is shifted down into subnormal form and rounded again. With the trap on, the result keeps its rounded significand and its exponent is wrapped by 192, so that a handler can rescale it. Tininess is judged after rounding: a trial rounding decides whether a value at exponent zero would have reached the normal range.

The operand beat and the result beat are both valid/ready streams. The rounding mode and the trap enables travel with each input beat. One register stage separates them, so a result appears one cycle after it is accepted. A result held under back-pressure stays unchanged, and the input is refused until the held result leaves.

Top module: `mul_round_unit`

## Requirements
- R1: An accepted beat (`in_valid` and `in_ready` high at a clock edge) produces `out_valid` at the next edge. `in_ready` is high exactly when no result is held or `out_ready` is high. A result held with `out_ready` low keeps its value and its flags.
- R2: Mode code 0 rounds to nearest even: the fraction is incremented when guard is set and either sticky or the fraction LSB is set.
- R3: Mode code 1 never increments. Code 2 increments only positive inexact results. Code 3 increments only negative inexact results.
- R4: A rounding carry out of the 23-bit fraction clears the fraction and increments the exponent.
- R5: If the rounded exponent is 255 or more and the overflow trap is off, the overflow flag is raised and inexact is reported. The result is infinity for mode 0, for mode 2 when positive and for mode 3 when negative. In every other case it is the largest finite value of that sign.
- R6: If the overflow trap is on and overflow occurs, trap bit 2 is set and the result exponent field is the rounded exponent minus 192. The fraction stays rounded and no overflow flag is raised.
- R7: If the underflow trap is on, normal rounding also applies to exponents of zero or below. A rounded exponent of zero or below then sets trap bit 1 and gives an exponent field of that exponent plus 192.
- R8: If the underflow trap is off and the exponent is zero or below, the significand is shifted right by (1 - exponent), and the bits shifted out feed new guard and sticky bits. The value is then rounded by the mode rules into a subnormal, or into the smallest normal value. The underflow flag is raised only if the value is tiny and this step is inexact.
- R9: At exponent zero with an inexact input, the value is not tiny when a trial rounding of the full 24-bit significand would carry out of it.
- R10: Inexact (guard or sticky set, or forced by overflow) sets trap bit 0 when the inexact trap is on; otherwise it sets flag bit 0. It never sets both.
- R11: The result packs the sign in bit 31, the exponent in bits 30:23 and the fraction in bits 22:0. The flag, trap and trap-enable vectors all use bit 2 for overflow, bit 1 for underflow and bit 0 for inexact. An exact normal result raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat valid |
| in_ready | output | 1 | Unit can take an operand beat |
| in_sign | input | 1 | Sign of the product |
| in_exp | input | 10 | Signed biased exponent before rounding |
| in_sig | input | 24 | Significand, hidden bit at bit 23 |
| in_guard | input | 1 | First bit below the significand |
| in_sticky | input | 1 | OR of all lower product bits |
| in_rmode | input | 2 | Rounding mode code |
| in_trap_en | input | 3 | Trap enables: overflow, underflow, inexact |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer takes the result beat |
| out_result | output | 32 | Packed single-precision result |
| out_flags | output | 3 | Status flags to raise |
| out_trap | output | 3 | Trap causes |

## Verification
In a single operation, a rounding carry can push the exponent to 255 and so turn into overflow. One case drives exponent 254 with an all-ones significand and guard set under round to nearest. The expected result is infinity with overflow and inexact flags when the trap is off. With the overflow trap on, it is a zero fraction under wrapped exponent 63 with the overflow cause. At exponent zero, the tininess trial and the denormalizing rounding also meet in one operation. They are judged together by checking that a carry into the smallest normal value raises inexact without underflow, while round toward zero leaves the largest subnormal with both flags.

// File: rtl/mr_pkg.sv
package mr_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_POS  = 2'd2,
    RM_NEG  = 2'd3
  } rmode_e;

  localparam int EXC_OVF = 2;
  localparam int EXC_UNF = 1;
  localparam int EXC_INX = 0;
  localparam int EXC_W   = 3;
endpackage

// File: rtl/mr_round_dec.sv
module mr_round_dec
  import mr_pkg::*;
(
  input  rmode_e mode_i,
  input  logic   sign_i,
  input  logic   lsb_i,
  input  logic   guard_i,
  input  logic   sticky_i,
  output logic   inc_o
);
  logic lost;
  assign lost = guard_i | sticky_i;

  always_comb begin
    unique case (mode_i)
      RM_NEAR: inc_o = guard_i & (sticky_i | lsb_i);
      RM_ZERO: inc_o = 1'b0;
      RM_POS:  inc_o = lost & ~sign_i;
      RM_NEG:  inc_o = lost & sign_i;
      default: inc_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mr_denorm.sv
module mr_denorm #(
  parameter int SIGW = 24,
  parameter int EXPW = 10
) (
  input  logic signed [EXPW-1:0] exp_i,
  input  logic [SIGW-1:0]        sig_i,
  input  logic                   guard_i,
  input  logic                   sticky_i,
  output logic [SIGW-1:0]        val_o,
  output logic                   guard_o,
  output logic                   sticky_o
);
  localparam int SHMAX = SIGW + 2;
  localparam int WW    = SIGW + SHMAX;
  localparam int SHW   = $clog2(SHMAX + 1);

  logic [EXPW:0]  amt;
  logic [SHW-1:0] sh;
  logic [WW-1:0]  wide;

  always_comb begin
    amt = (EXPW+1)'(1) - {exp_i[EXPW-1], exp_i};
    if (amt[EXPW])
      sh = '0;
    else if (amt > (EXPW+1)'(SHMAX))
      sh = SHW'(SHMAX);
    else
      sh = SHW'(amt);
    wide     = {sig_i, {SHMAX{1'b0}}} >> sh;
    val_o    = wide[WW-1 -: SIGW];
    guard_o  = wide[SHMAX-1];
    sticky_o = guard_i | sticky_i | (|wide[SHMAX-2:0]);
  end
endmodule

// File: rtl/mr_core.sv
module mr_core
  import mr_pkg::*;
#(
  parameter int EXPW  = 10,
  parameter int FRACW = 23,
  parameter int EXPF  = 8,
  parameter int WRAP  = 192
) (
  input  logic                   sign_i,
  input  logic signed [EXPW-1:0] exp_i,
  input  logic [FRACW:0]         sig_i,
  input  logic                   guard_i,
  input  logic                   sticky_i,
  input  logic [1:0]             rmode_i,
  input  logic [EXC_W-1:0]       trap_en_i,
  output logic [FRACW+EXPF:0]    result_o,
  output logic [EXC_W-1:0]       flags_o,
  output logic [EXC_W-1:0]       trap_o
);
  localparam int SIGW = FRACW + 1;
  localparam int EMAX = (1 << EXPF) - 1;
  localparam logic signed [EXPW:0]   EMAX_S = (EXPW+1)'(EMAX);
  localparam logic signed [EXPW:0]   ZERO_S = '0;
  localparam logic signed [EXPW-1:0] EZ     = '0;
  localparam logic signed [EXPW:0]   WRAP_S = (EXPW+1)'(WRAP);

  rmode_e mode;
  assign mode = rmode_e'(rmode_i);

  logic inexact;
  assign inexact = guard_i | sticky_i;

  // main rounding in normal position
  logic inc_n, do_rnd;
  mr_round_dec u_rnd_main (
    .mode_i(mode), .sign_i(sign_i), .lsb_i(sig_i[0]),
    .guard_i(guard_i), .sticky_i(sticky_i), .inc_o(inc_n)
  );
  assign do_rnd = inc_n & ((exp_i > EZ) | trap_en_i[EXC_UNF]);

  logic [FRACW:0]          frac_r;
  logic signed [EXPW:0]    exp_r;
  assign frac_r = {1'b0, sig_i[FRACW-1:0]} + {{FRACW{1'b0}}, do_rnd};
  assign exp_r  = $signed({exp_i[EXPW-1], exp_i}) + $signed({{EXPW{1'b0}}, frac_r[FRACW]});

  logic is_ovf, is_unf;
  assign is_ovf = exp_r >= EMAX_S;
  assign is_unf = exp_r <= ZERO_S;

  // trial rounding on the full significand for the tininess test
  logic inc_t, not_tiny;
  mr_round_dec u_rnd_trial (
    .mode_i(mode), .sign_i(sign_i), .lsb_i(sig_i[0]),
    .guard_i(guard_i), .sticky_i(sticky_i), .inc_o(inc_t)
  );
  assign not_tiny = (exp_i == EZ) & inexact & inc_t & (&sig_i);

  // denormalize and round again
  logic [SIGW-1:0] dval, dval_r;
  logic            dg, ds, inc_d, d_inexact;
  mr_denorm #(.SIGW(SIGW), .EXPW(EXPW)) u_denorm (
    .exp_i(exp_i), .sig_i(sig_i), .guard_i(guard_i), .sticky_i(sticky_i),
    .val_o(dval), .guard_o(dg), .sticky_o(ds)
  );
  mr_round_dec u_rnd_sub (
    .mode_i(mode), .sign_i(sign_i), .lsb_i(dval[0]),
    .guard_i(dg), .sticky_i(ds), .inc_o(inc_d)
  );
  assign dval_r    = dval + {{(SIGW-1){1'b0}}, inc_d};
  assign d_inexact = dg | ds;

  logic signed [EXPW:0] wrap_dn, wrap_up;
  assign wrap_dn = exp_r - WRAP_S;
  assign wrap_up = exp_r + WRAP_S;

  logic use_inf;
  assign use_inf = (mode == RM_NEAR) | ((mode == RM_POS) & ~sign_i) |
                   ((mode == RM_NEG) & sign_i);

  always_comb begin
    flags_o  = '0;
    trap_o   = '0;
    result_o = {sign_i, exp_r[EXPF-1:0], frac_r[FRACW-1:0]};
    if (is_ovf) begin
      if (trap_en_i[EXC_OVF]) begin
        result_o = {sign_i, wrap_dn[EXPF-1:0], frac_r[FRACW-1:0]};
        trap_o[EXC_OVF] = 1'b1;
        if (inexact) begin
          if (trap_en_i[EXC_INX]) trap_o[EXC_INX] = 1'b1;
          else                    flags_o[EXC_INX] = 1'b1;
        end
      end else begin
        flags_o[EXC_OVF] = 1'b1;
        if (trap_en_i[EXC_INX]) trap_o[EXC_INX] = 1'b1;
        else                    flags_o[EXC_INX] = 1'b1;
        if (use_inf)
          result_o = {sign_i, {EXPF{1'b1}}, {FRACW{1'b0}}};
        else
          result_o = {sign_i, {(EXPF-1){1'b1}}, 1'b0, {FRACW{1'b1}}};
      end
    end else if (is_unf) begin
      if (trap_en_i[EXC_UNF]) begin
        result_o = {sign_i, wrap_up[EXPF-1:0], frac_r[FRACW-1:0]};
        trap_o[EXC_UNF] = 1'b1;
        if (inexact) begin
          if (trap_en_i[EXC_INX]) trap_o[EXC_INX] = 1'b1;
          else                    flags_o[EXC_INX] = 1'b1;
        end
      end else begin
        result_o = {sign_i, {(EXPF-1){1'b0}}, dval_r};
        if (d_inexact) begin
          if (!not_tiny) flags_o[EXC_UNF] = 1'b1;
          if (trap_en_i[EXC_INX]) trap_o[EXC_INX] = 1'b1;
          else                    flags_o[EXC_INX] = 1'b1;
        end
      end
    end else if (inexact) begin
      if (trap_en_i[EXC_INX]) trap_o[EXC_INX] = 1'b1;
      else                    flags_o[EXC_INX] = 1'b1;
    end
  end
endmodule

// File: rtl/mul_round_unit.sv
module mul_round_unit
  import mr_pkg::*;
#(
  parameter int EXPW  = 10,
  parameter int FRACW = 23,
  parameter int EXPF  = 8,
  parameter int WRAP  = 192
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_sign,
  input  logic signed [EXPW-1:0] in_exp,
  input  logic [FRACW:0]         in_sig,
  input  logic                   in_guard,
  input  logic                   in_sticky,
  input  logic [1:0]             in_rmode,
  input  logic [EXC_W-1:0]       in_trap_en,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [FRACW+EXPF:0]    out_result,
  output logic [EXC_W-1:0]       out_flags,
  output logic [EXC_W-1:0]       out_trap
);
  localparam int RESW = 1 + EXPF + FRACW;

  logic [RESW-1:0]  c_result;
  logic [EXC_W-1:0] c_flags, c_trap;
  logic             take;

  mr_core #(.EXPW(EXPW), .FRACW(FRACW), .EXPF(EXPF), .WRAP(WRAP)) u_core (
    .sign_i(in_sign), .exp_i(in_exp), .sig_i(in_sig),
    .guard_i(in_guard), .sticky_i(in_sticky),
    .rmode_i(in_rmode), .trap_en_i(in_trap_en),
    .result_o(c_result), .flags_o(c_flags), .trap_o(c_trap)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_flags  <= '0;
      out_trap   <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        out_result <= c_result;
        out_flags  <= c_flags;
        out_trap   <= c_trap;
      end
    end
  end
endmodule

// File: rtl/mr_chk.sv
module mr_chk #(
  parameter int RESW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [RESW-1:0] out_result,
  input logic [2:0]      out_flags,
  input logic [2:0]      out_trap
);
  // R1: a stalled result holds value and status
  a_r1_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
                                $stable(out_flags) && $stable(out_trap));
  // R1: no operand taken while a result is stalled
  a_r1_block_in: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R1: one-cycle latency
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R1: drained output with no new beat goes idle
  a_r1_drain: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
  // R5: saturating overflow always reports inexact
  a_r5_ovf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[2] |-> (out_flags[0] || out_trap[0]));
  // R6: trapped overflow raises no range flag
  a_r6_trap_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_trap[2] |-> !out_flags[2] && !out_flags[1]);
  // R6 R7: at most one range trap
  a_r7_one_range_trap: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_trap[2] && out_trap[1]));
  // R8: underflow flag only with inexact
  a_r8_unf_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_flags[1] |-> (out_flags[0] || out_trap[0]));
  // R10: inexact is a trap or a flag, never both
  a_r10_inx_once: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_flags[0] && out_trap[0]));
endmodule

bind mul_round_unit mr_chk #(.RESW(RESW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_flags(out_flags), .out_trap(out_trap)
);

// File: tb/sim_mul_round_unit.sv
module sim_mul_round_unit;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, in_valid, in_ready, in_sign, in_guard, in_sticky;
  logic signed [9:0] in_exp;
  logic [23:0]       in_sig;
  logic [1:0]        in_rmode;
  logic [2:0]        in_trap_en, out_flags, out_trap;
  logic              out_valid, out_ready;
  logic [31:0]       out_result;

  int n_chk = 0;
  int n_err = 0;

  mul_round_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
    .in_guard(in_guard), .in_sticky(in_sticky), .in_rmode(in_rmode),
    .in_trap_en(in_trap_en), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_flags(out_flags), .out_trap(out_trap)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] xp);
    n_chk++;
    if (act !== xp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, xp);
    end
  endtask

  task automatic drive(logic sg, int e, logic [23:0] sig, logic g, logic s,
                       logic [1:0] m, logic [2:0] te);
    in_sign = sg; in_exp = 10'(e); in_sig = sig; in_guard = g;
    in_sticky = s; in_rmode = m; in_trap_en = te;
  endtask

  task automatic op(string tag, logic sg, int e, logic [23:0] sig, logic g,
                    logic s, logic [1:0] m, logic [2:0] te,
                    logic [31:0] xr, logic [2:0] xf, logic [2:0] xt);
    @(negedge clk);
    drive(sg, e, sig, g, s, m, te);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " valid"}, 32'(out_valid), 32'd1);
    chk({tag, " result"}, out_result, xr);
    chk({tag, " flags"}, 32'(out_flags), 32'(xf));
    chk({tag, " trap"}, 32'(out_trap), 32'(xt));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    drive(1'b0, 0, 24'h0, 1'b0, 1'b0, 2'd0, 3'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset out_valid", 32'(out_valid), 32'd0);
    chk("R1 reset in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
  endtask

  task automatic t_exact;
    op("R11 exact normal", 1'b0, 127, 24'hC00000, 0, 0, 2'd0, 3'd0, 32'h3FC00000, 3'b000, 3'b000);
  endtask

  task automatic t_nearest;
    op("R2 tie even kept", 1'b0, 128, 24'h800000, 1, 0, 2'd0, 3'd0, 32'h40000000, 3'b001, 3'b000);
    op("R2 tie odd up",    1'b0, 128, 24'h800001, 1, 0, 2'd0, 3'd0, 32'h40000002, 3'b001, 3'b000);
    op("R2 above half",    1'b0, 128, 24'h800000, 1, 1, 2'd0, 3'd0, 32'h40000001, 3'b001, 3'b000);
  endtask

  task automatic t_directed;
    op("R3 zero neg",  1'b1, 128, 24'h800000, 0, 1, 2'd1, 3'd0, 32'hC0000000, 3'b001, 3'b000);
    op("R3 plus neg",  1'b1, 128, 24'h800000, 0, 1, 2'd2, 3'd0, 32'hC0000000, 3'b001, 3'b000);
    op("R3 minus neg", 1'b1, 128, 24'h800000, 0, 1, 2'd3, 3'd0, 32'hC0000001, 3'b001, 3'b000);
    op("R3 plus pos",  1'b0, 128, 24'h800000, 0, 1, 2'd2, 3'd0, 32'h40000001, 3'b001, 3'b000);
  endtask

  task automatic t_carry;
    op("R4 carry", 1'b0, 100, 24'hFFFFFF, 1, 0, 2'd0, 3'd0, 32'h32800000, 3'b001, 3'b000);
  endtask

  task automatic t_ovf_sat;
    op("R5 near inf",    1'b0, 300, 24'h800000, 0, 1, 2'd0, 3'd0, 32'h7F800000, 3'b101, 3'b000);
    op("R5 zero max",    1'b0, 300, 24'h800000, 0, 1, 2'd1, 3'd0, 32'h7F7FFFFF, 3'b101, 3'b000);
    op("R5 plus neg",    1'b1, 300, 24'h800000, 0, 1, 2'd2, 3'd0, 32'hFF7FFFFF, 3'b101, 3'b000);
    op("R5 minus neg",   1'b1, 300, 24'h800000, 0, 1, 2'd3, 3'd0, 32'hFF800000, 3'b101, 3'b000);
    op("R5 exact 255",   1'b0, 255, 24'h800000, 0, 0, 2'd0, 3'd0, 32'h7F800000, 3'b101, 3'b000);
    op("R5 R4 carry ovf",1'b0, 254, 24'hFFFFFF, 1, 0, 2'd0, 3'd0, 32'h7F800000, 3'b101, 3'b000);
  endtask

  task automatic t_ovf_trap;
    op("R6 carry wrap",    1'b0, 254, 24'hFFFFFF, 1, 0, 2'd0, 3'b100, 32'h1F800000, 3'b001, 3'b100);
    op("R6 R10 inx trap",  1'b0, 254, 24'hFFFFFF, 1, 0, 2'd0, 3'b101, 32'h1F800000, 3'b000, 3'b101);
    op("R6 exact wrap",    1'b0, 300, 24'hC00000, 0, 0, 2'd0, 3'b100, 32'h36400000, 3'b000, 3'b100);
  endtask

  task automatic t_unf_trap;
    op("R7 rounded wrap", 1'b0, -10, 24'h800001, 1, 1, 2'd0, 3'b010, 32'h5B000002, 3'b001, 3'b010);
    op("R7 exact zero",   1'b0, 0,   24'h800000, 0, 0, 2'd0, 3'b010, 32'h60000000, 3'b000, 3'b010);
  endtask

  task automatic t_denorm;
    op("R8 exact sub",      1'b0, 0,   24'h800000, 0, 0, 2'd0, 3'd0, 32'h00400000, 3'b000, 3'b000);
    op("R8 shift3 near",    1'b0, -2,  24'hC00001, 0, 0, 2'd0, 3'd0, 32'h00180000, 3'b011, 3'b000);
    op("R8 shift3 plus",    1'b0, -2,  24'hC00001, 0, 0, 2'd2, 3'd0, 32'h00180001, 3'b011, 3'b000);
    op("R8 R10 inx trap",   1'b0, -2,  24'hC00001, 0, 0, 2'd0, 3'b001, 32'h00180000, 3'b010, 3'b001);
    op("R8 deep near",      1'b1, -40, 24'h800000, 0, 0, 2'd0, 3'd0, 32'h80000000, 3'b011, 3'b000);
    op("R8 deep plus",      1'b0, -40, 24'h800000, 0, 0, 2'd2, 3'd0, 32'h00000001, 3'b011, 3'b000);
  endtask

  task automatic t_tiny;
    op("R9 carry not tiny", 1'b0, 0, 24'hFFFFFF, 1, 0, 2'd0, 3'd0, 32'h00800000, 3'b001, 3'b000);
    op("R9 zero mode tiny", 1'b0, 0, 24'hFFFFFF, 1, 0, 2'd1, 3'd0, 32'h007FFFFF, 3'b011, 3'b000);
    op("R9 no trial carry", 1'b0, 0, 24'hFFFFFE, 1, 0, 2'd0, 3'd0, 32'h007FFFFF, 3'b011, 3'b000);
  endtask

  task automatic t_inexact_trap;
    op("R10 normal trap", 1'b0, 128, 24'h800000, 1, 1, 2'd0, 3'b001, 32'h40000001, 3'b000, 3'b001);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    out_ready = 1'b0;
    drive(1'b0, 127, 24'hC00000, 0, 0, 2'd0, 3'd0);
    in_valid = 1'b1;
    @(negedge clk);
    chk("R1 bp valid A", 32'(out_valid), 32'd1);
    chk("R1 bp in_ready low", 32'(in_ready), 32'd0);
    chk("R1 bp result A", out_result, 32'h3FC00000);
    drive(1'b1, 128, 24'h800000, 0, 1, 2'd3, 3'd0);
    repeat (2) @(negedge clk);
    chk("R1 bp hold A", out_result, 32'h3FC00000);
    chk("R1 bp hold flags", 32'(out_flags), 32'd0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R1 bp valid B", 32'(out_valid), 32'd1);
    chk("R1 bp result B", out_result, 32'hC0000001);
    chk("R1 bp flags B", 32'(out_flags), 32'd1);
    @(negedge clk);
    chk("R1 bp idle", 32'(out_valid), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    t_reset();
    t_exact();
    t_nearest();
    t_directed();
    t_carry();
    t_ovf_sat();
    t_ovf_trap();
    t_unf_trap();
    t_denorm();
    t_tiny();
    t_inexact_trap();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule